// File: doc/BRIEF.md
# Microsecond Tick Prescaler and Counter

This block turns a free-running reference clock into a steady 1 MHz tick and keeps a 32-bit count of the microseconds that have elapsed. The reference clock can have any of several fixed rates. The divide is fractional: a small ratio register holds a multiplier (the dividend) and a divisor. On every reference clock the dividend is added to a phase accumulator. The tick fires whenever that accumulator reaches the divisor, and the divisor is then taken back out. This lets the block make an exact average of one tick per microsecond from clocks such as 19.2 MHz, where a plain integer divide cannot.

Software reaches the block through a simple register port:

- The ratio register can be written and read back.
- The microsecond count is read-only.
- The tick pulse is also driven out on a pin, so that downstream timers can count the same microseconds.

Ratio values for common clocks:

| Clock | Ratio value | Dividend / divisor |
|---|---|---|
| 12 MHz | 0x000b | 1/12 |
| 13 MHz | 0x000c | 1/13 |
| 26 MHz | 0x0019 | 1/26 |
| 19.2 MHz | 0x045f | 5/96 |

Top module: `usec_tick_timer`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, `tick_o` is 0, the count reads 0 and the ratio register reads 0x0000000b.
- R2: A write at offset 0x14 loads `reg_wdata[15:0]` into the ratio register, and the written bits [31:16] are dropped. A read at 0x14 returns the stored value in bits [15:0], with zeros above. Bits [15:8] hold the dividend minus one and bits [7:0] hold the divisor minus one.
- R3: Let D be the dividend, N the divisor, and k the number of rising edges since the last reset release or ratio write. The registered `tick_o` is high after edge k exactly when floor(k·D/N) > floor((k−1)·D/N). When D ≥ N, this means every cycle.
- R4: A read at offset 0x10 returns the microsecond count. The count goes up by one on exactly the edges after which `tick_o` is high, and never changes otherwise.
- R5: The edge that takes a ratio write produces no tick, and it restarts the phase, so that edge counts as k = 0 for R3.
- R6: Writes to offset 0x10 or to any offset other than 0x14 change neither the count, the ratio register nor the tick phase.
- R7: Reads at any offset other than 0x10 and 0x14 return 0.
- R8: The count wraps from all ones to zero on the next tick, with no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| reg_we | input | 1 | Register write strobe, taken on the rising edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from the current state |
| tick_o | output | 1 | One-cycle microsecond tick, registered |

## Verification
- A ratio write takes effect on the edge that samples it, so a read of 0x14 in the following cycle already returns the new value.
- The tick and the count change together on one edge. That edge is the k-th edge after a reset release or a ratio write, where k is the first value that crosses a multiple of the divisor.
- The reference model in the bench counts edges and uses integer division to decide which edges carry a tick. It updates once per edge, using the inputs that were present before that edge.
- The bench changes its inputs one nanosecond after each edge and compares `tick_o` and `reg_rdata` at that same point. `reg_rdata` is taken with the address still held, so every result is read exactly one edge after the stimulus that caused it.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

  localparam int unsigned RATIO_FIELD_W = 8;

  typedef struct packed {
    logic [RATIO_FIELD_W-1:0] dividend_m1;
    logic [RATIO_FIELD_W-1:0] divisor_m1;
  } ratio_cfg_t;

  localparam int unsigned RATIO_W = 2 * RATIO_FIELD_W;

  // 12 MHz reference: one tick every twelve clocks
  localparam ratio_cfg_t RATIO_RST = '{dividend_m1: 8'h00, divisor_m1: 8'h0b};

endpackage

// File: rtl/usec_cfg_regs.sv
module usec_cfg_regs
  import usec_tick_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CFG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  output ratio_cfg_t        cfg_o,
  output logic              cfg_wr_o,
  output logic [DATA_W-1:0] reg_rdata
);

  ratio_cfg_t cfg_q;
  ratio_cfg_t cfg_d;
  logic       cfg_en;

  // Only the ratio offset is writable; everything else is dropped here
  always_comb begin
    cfg_en = reg_we && (reg_addr == CFG_OFS);
    cfg_d  = ratio_cfg_t'(reg_wdata[RATIO_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RATIO_RST;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CNT_OFS) begin
      reg_rdata[CNT_W-1:0] = cnt_i;
    end else if (reg_addr == CFG_OFS) begin
      reg_rdata[RATIO_W-1:0] = cfg_q;
    end
  end

  assign cfg_o    = cfg_q;
  assign cfg_wr_o = cfg_en;

endmodule

// File: rtl/usec_frac_acc.sv
module usec_frac_acc #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [FIELD_W-1:0] dividend_m1,
  input  logic [FIELD_W-1:0] divisor_m1,
  output logic               tick_nxt_o,
  output logic               tick_o
);

  localparam int unsigned ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] dividend;
  logic [ACC_W-1:0] divisor;
  logic [ACC_W-1:0] sum;
  logic             tick_q;
  logic             tick_d;

  always_comb begin
    dividend = {2'b00, dividend_m1} + ACC_W'(1);
    divisor  = {2'b00, divisor_m1} + ACC_W'(1);
    sum      = acc_q + dividend;
    if (clr_i) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (dividend >= divisor) begin
      // Ratio of one or more: tick every clock, keep no residue
      acc_d  = '0;
      tick_d = 1'b1;
    end else if (sum >= divisor) begin
      acc_d  = sum - divisor;
      tick_d = 1'b1;
    end else begin
      acc_d  = sum;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_nxt_o = tick_d;
  assign tick_o     = tick_q;

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Natural binary wrap from all ones to zero
  always_comb cnt_d = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
  import usec_tick_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter logic [ADDR_W-1:0] CNT_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CFG_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_o
);

  ratio_cfg_t       cfg_q;
  logic             cfg_wr;
  logic             tick_nxt;
  logic [CNT_W-1:0] cnt_q;

  usec_cfg_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CNT_OFS(CNT_OFS),
    .CFG_OFS(CFG_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .cnt_i    (cnt_q),
    .cfg_o    (cfg_q),
    .cfg_wr_o (cfg_wr),
    .reg_rdata(reg_rdata)
  );

  usec_frac_acc #(
    .FIELD_W(RATIO_FIELD_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cfg_wr),
    .dividend_m1(cfg_q.dividend_m1),
    .divisor_m1 (cfg_q.divisor_m1),
    .tick_nxt_o (tick_nxt),
    .tick_o     (tick_o)
  );

  usec_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc_i(tick_nxt),
    .cnt_o(cnt_q)
  );

endmodule

// File: rtl/usec_tick_timer_chk.sv
module usec_tick_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [15:0]      wr_data,
  input logic [15:0]      cfg_val,
  input logic             tick,
  input logic [CNT_W-1:0] cnt
);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_val == $past(wr_data)));

  // R5
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tick);

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt != $past(cnt)) == tick));

  // R8
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(cnt)) && tick) |-> (cnt == '0));

endmodule

bind usec_tick_timer usec_tick_timer_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_wr (cfg_wr),
  .wr_data(reg_wdata[15:0]),
  .cfg_val(cfg_q),
  .tick   (tick_o),
  .cnt    (cnt_q)
);

// File: tb/tb_usec_tick_timer.sv
`timescale 1ns/1ps
module tb_usec_tick_timer;

  localparam logic [7:0] CNT_OFS = 8'h10;
  localparam logic [7:0] CFG_OFS = 8'h14;
  localparam int unsigned SMALL_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = CFG_OFS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic [31:0] rdata_w;
  logic        tick;
  logic        tick_w;

  int vectors = 0;
  int fails = 0;

  // reference state
  logic [15:0] m_cfg;
  longint      m_k;
  logic [31:0] m_cnt;
  logic        m_tick;

  always #2 clk = ~clk;

  usec_tick_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .tick_o(tick)
  );

  usec_tick_timer #(.CNT_W(SMALL_W)) dut_w (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_w), .tick_o(tick_w)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    longint d;
    longint n;
    if (!rst_n) begin
      m_cfg = 16'h000b; m_k = 0; m_cnt = 0; m_tick = 1'b0;
    end else if (reg_we && reg_addr == CFG_OFS) begin
      m_cfg = reg_wdata[15:0]; m_k = 0; m_tick = 1'b0;   // R5 restart
    end else begin
      m_k++;
      d = longint'(m_cfg[15:8]) + 1;
      n = longint'(m_cfg[7:0]) + 1;
      m_tick = ((m_k * d) / n) != (((m_k - 1) * d) / n);
      if (m_tick) m_cnt = m_cnt + 32'd1;
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] cnt);
    if (reg_addr == CNT_OFS) return cnt;
    if (reg_addr == CFG_OFS) return {16'h0, m_cfg};
    return 32'h0;
  endfunction

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
    string rq;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    model_edge();
    chk("R3 tick", {31'h0, tick}, {31'h0, m_tick});
    chk("R3 tick small", {31'h0, tick_w}, {31'h0, m_tick});
    rq = (a == CNT_OFS) ? "R4 count read" : (a == CFG_OFS) ? "R2 ratio read" : "R7 unmapped read";
    chk(rq, rdata, exp_read(m_cnt));
    chk({rq, " R8 small"}, rdata_w, exp_read(m_cnt & ((32'd1 << SMALL_W) - 1)));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, (i % 2) ? CNT_OFS : CFG_OFS, 32'h0);
  endtask

  initial begin
    // R1 reset state
    cyc(1'b0, CFG_OFS, 32'h0);
    cyc(1'b0, CNT_OFS, 32'h0);
    rst_n = 1'b1;
    cyc(1'b0, CNT_OFS, 32'h0);
    chk("R1 count after release", rdata, 32'h0);
    cyc(1'b0, CFG_OFS, 32'h0);
    chk("R1 ratio after release", rdata, 32'h0000000b);
    run(40);                              // 12 MHz: 1/12
    cyc(1'b1, CFG_OFS, 32'h0000045f);     // 19.2 MHz: 5/96
    run(250);
    cyc(1'b1, CFG_OFS, 32'hffff000c);     // R2 upper bits dropped
    chk("R2 upper bits", rdata, 32'h0000000c);
    run(20);
    cyc(1'b1, CNT_OFS, 32'h12345678);     // R6 count not writable
    cyc(1'b1, 8'h20, 32'h000000ff);       // R6 other offset ignored
    cyc(1'b1, 8'h18, 32'h00000000);
    run(30);
    cyc(1'b0, 8'h30, 32'h0);              // R7
    cyc(1'b1, CFG_OFS, 32'h00000000);     // 1/1: every cycle, R8 wrap on small count
    run(150);
    cyc(1'b1, CFG_OFS, 32'h00000300);     // 4/1 saturates
    run(20);
    cyc(1'b1, CFG_OFS, 32'h00000019);     // 26 MHz: 1/26
    run(80);
    cyc(1'b1, CFG_OFS, 32'h00000019);     // back-to-back rewrite restarts phase
    cyc(1'b1, CFG_OFS, 32'h00000019);
    run(60);
    rst_n = 1'b0;                         // R1 reset mid-run
    cyc(1'b0, CNT_OFS, 32'h0);
    chk("R1 count in reset", rdata, 32'h0);
    rst_n = 1'b1;
    run(30);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule